// File: doc/BRIEF.md
# Broadcast-Free Second-Order 2-D Recursive Image Filter

This block filters a raster-scanned image with a second-order two-dimensional recursive (IIR) difference equation. One pixel enters per clock in row-wise order, and one filtered pixel leaves per clock. The image width `M` and both 3x3 coefficient sets are parameters.

The recurrence is split by row lag. For row lag `i`, a term combines a three-tap horizontal FIR on the input with a three-tap horizontal FIR on the output. The lag-2 term passes through a row-length shift register. It is then added to the lag-1 term. That sum passes through a second row-length shift register and joins the lag-0 term.

Every value travels only to the next delay element or adder. The feedback loop is therefore one multiply followed by a short adder tree. The pipeline moves only on cycles that carry a valid input pixel. Reset clears all history, so samples before the frame count as zero.

Top module: `iir2d_systolic`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `y_out` are zero in the following cycle. All horizontal and row history is cleared, so the first outputs after reset see zero for every earlier sample.
- R2: Data and coefficients are W-bit two's complement values with F fraction bits. Each product c·v is rounded as (c·v + 2^(F-1)) >> F with an arithmetic shift. It is then cut to its low W bits. Sums wrap modulo 2^W.
- R3: For the n-th valid sample since reset, y[n] = Σ a[i][j]·x[n−iM−j] + Σ b[i][j]·y[n−iM−j], summed over i and j in 0..2 and using the R2 arithmetic. Coefficient a[i][j] is index 3i+j of parameter `A`, and b[i][j] is index 3i+j of parameter `B`. Terms with a negative index are zero.
- R4: A cycle with `in_valid` high is followed by a cycle with `out_valid` high, in which `y_out` carries y[n].
- R5: A cycle with `in_valid` low advances no history. The next cycle has `out_valid` low and `y_out` unchanged.
- R6: The horizontal lags j = 1 and j = 2 reach back to the previous samples in raster order, including across a row boundary.
- R7: The row lag i is exactly i·M valid samples, so an impulse reappears through a[1][0] after M samples and through a[2][0] after 2M samples.
- R8: The coefficient b[0][0] is never used. The current output feeds back only through b[0][1], b[0][2] and the lags i ≥ 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present; advances the pipeline |
| x_in | input | W | Input pixel, signed fixed point |
| out_valid | output | 1 | Output pixel present |
| y_out | output | W | Filtered pixel, signed fixed point |

## Verification
Two things can land on the same sample: a row-lag contribution arriving through the row shift registers, and the recursive feedback from the previous output. An impulse is fed in, followed by more than two rows of zeros. The lag-M and lag-2M echoes then overlap with the decaying feedback tail, and each output is compared with a reference recurrence computed from the sample history. Random pixel streams with idle gaps and a mid-frame reset check that the gaps neither move the row alignment nor disturb the held output.

// File: rtl/iir2d_systolic.sv
module iir2d_systolic #(
  parameter int W = 12,
  parameter int F = 8,
  parameter int M = 16,
  parameter int A [9] = '{64, 32, 16, 32, 16, 8, 16, 8, 4},
  parameter int B [9] = '{0, 32, -16, 32, 16, -8, -16, 8, 4}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] x_in,
  output logic                out_valid,
  output logic signed [W-1:0] y_out
);
  localparam int PW = 2 * W;

  function automatic logic signed [W-1:0] mulr(input int c, input logic signed [W-1:0] v);
    logic signed [W-1:0]  cw;
    logic signed [PW-1:0] p;
    cw = W'(c);
    p  = PW'(cw) * PW'(v);
    p  = p + PW'(1 <<< (F - 1));
    return p[F +: W];
  endfunction

  logic signed [W-1:0] x1, x2, y2, ycur;
  logic signed [W-1:0] term [3];
  logic signed [W-1:0] row2 [M];
  logic signed [W-1:0] row1 [M];

  for (genvar i = 0; i < 3; i++) begin : g_lag
    logic signed [W-1:0] fir_x, fir_y;
    assign fir_x = mulr(A[3*i], x_in) + mulr(A[3*i+1], x1) + mulr(A[3*i+2], x2);
    if (i == 0) begin : g_self
      assign fir_y = mulr(B[1], y_out) + mulr(B[2], y2);
    end else begin : g_rec
      assign fir_y = mulr(B[3*i], ycur) + (mulr(B[3*i+1], y_out) + mulr(B[3*i+2], y2));
    end
    assign term[i] = fir_x + fir_y;
  end

  assign ycur = term[0] + row1[M-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      x1 <= '0;
      x2 <= '0;
      y2 <= '0;
      y_out <= '0;
      out_valid <= 1'b0;
      for (int k = 0; k < M; k++) begin
        row1[k] <= '0;
        row2[k] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x1 <= x_in;
        x2 <= x1;
        y2 <= y_out;
        y_out <= ycur;
        row2[0] <= term[2];
        row1[0] <= term[1] + row2[M-1];
        for (int k = 1; k < M; k++) begin
          row2[k] <= row2[k-1];
          row1[k] <= row1[k-1];
        end
      end
    end
  end
endmodule

// File: rtl/iir2d_systolic_chk.sv
module iir2d_systolic_chk #(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic signed [W-1:0] y_out,
  input logic signed [W-1:0] row_tap
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && y_out == '0));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(y_out)));

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(row_tap));
endmodule

bind iir2d_systolic iir2d_systolic_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .y_out(y_out), .row_tap(row1[M-1])
);

// File: tb/iir2d_systolic_bench.sv
module iir2d_systolic_bench;
  localparam int W = 12;
  localparam int F = 8;
  localparam int M = 16;
  localparam int A [9] = '{64, 32, 16, 32, 16, 8, 16, 8, 4};
  localparam int B [9] = '{0, 32, -16, 32, 16, -8, -16, 8, 4};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] x_in = '0;
  logic out_valid;
  logic signed [W-1:0] y_out;

  int checks = 0;
  int fails = 0;
  int xs[$];
  int ys[$];
  int exp_q[$];
  string tag_q[$];
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  iir2d_systolic #(.W(W), .F(F), .M(M), .A(A), .B(B)) u_iir2d_systolic (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
    .out_valid(out_valid), .y_out(y_out)
  );

  function automatic int wrapw(int v);
    int m;
    m = v & ((1 << W) - 1);
    return (m >= (1 << (W - 1))) ? m - (1 << W) : m;
  endfunction

  function automatic int rnd(int c, int v);
    return (c * v + (1 << (F - 1))) >>> F;
  endfunction

  function automatic int model();
    int n, s;
    n = xs.size() - 1;
    s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        int k;
        k = n - i * M - j;
        if (k >= 0) begin
          s += rnd(A[3*i+j], xs[k]);
          if (i + j > 0) s += rnd(B[3*i+j], ys[k]);
        end
      end
    return wrapw(s);
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic send(int x);
    int y;
    xs.push_back(wrapw(x));
    y = model();
    ys.push_back(y);
    exp_q.push_back(y);
    tag_q.push_back(tag);
    in_valid = 1'b1;
    x_in = W'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int cycles);
    for (int c = 0; c < cycles; c++) begin
      int held;
      held = int'(y_out);
      in_valid = 1'b0;
      @(negedge clk);
      check("R5 out_valid in gap", int'(out_valid), 0);
      check("R5 y_out held in gap", int'(y_out), held);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 y_out after reset", int'(y_out), 0);
    rst = 1'b0;
    xs.delete();
    ys.delete();
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected out_valid", 1, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(y_out), e);
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    tag = "R7 R8 R3 impulse";
    send(256);
    for (int n = 0; n < 3 * M + 4; n++) send(0);
    idle(2);
    tag = "R3 R6 R2 random";
    for (int n = 0; n < 5 * M; n++) begin
      send($urandom_range(3000) - 1500);
      if (n % 7 == 3) idle(1 + n % 3);
    end
    idle(2);
    tag = "R2 extremes";
    for (int n = 0; n < 2 * M; n++) send((n % 2) ? 2047 : -2048);
    idle(2);
    do_reset();
    tag = "R1 restart";
    for (int n = 0; n < 2 * M + 3; n++) send(100 + 37 * n);
    idle(2);
    check("R4 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule